// File: doc/BRIEF.md
# Modem Status Tracker with Loopback

This block keeps the modem status byte of a serial port. Its upper nibble reports the four modem line states: clear to send, data set ready, ring indicator and carrier detect. Its lower nibble holds sticky change flags, one for each line. In normal operation the line states come from the four external pins. Each pin passes through a synchroniser before it is captured.

When the loopback bit of the modem control byte is set, the external pins are ignored. The line states are then taken from the block's own modem control outputs. This lets software exercise the whole status and interrupt path without a cable. The change flags follow the same rules in both modes. The carrier, data-set and clear-to-send flags record any change of their line. The ring flag records only the trailing edge, a 1-to-0 transition. A read strobe on the status byte clears all four flags.

Top module: `modem_status_loop`

## Requirements
- R1: With the loopback bit (control bit 4) set, status bit 4 (clear to send) equals control bit 1 (request to send) as sampled on the previous clock edge.
- R2: With loopback set, status bit 5 (data set ready) equals control bit 0 (data terminal ready) from the previous edge.
- R3: With loopback set, status bit 6 (ring) equals control bit 2 and status bit 7 (carrier) equals control bit 3, both from the previous edge.
- R4: Status bits 0, 1 and 3 are set in the same cycle that status bit 4, 5 or 7 respectively takes a value different from its previous one, in either direction.
- R5: Status bit 2 is set only when status bit 6 goes from 1 to 0; a 0-to-1 transition of bit 6 does not set it.
- R6: Once set, a change flag (status bits 3:0) stays set until a read; no line activity clears it.
- R7: With loopback clear, status bits 7:4 follow the pins {carrier, ring, data set ready, clear to send} with a latency of SYNC_STAGES+1 cycles. Control bits 3:0 have no effect in that mode, and the pins have no effect while loopback is set. Control bits 7:5 never have an effect.
- R8: An asserted read strobe clears status bits 3:0 on the next edge. If a line change occurs in that same cycle, its flag is set anyway.
- R9: A synchronous active-high reset clears the whole status byte and the synchronisers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mcr_i | input | 8 | Modem control byte; bit 4 selects loopback |
| cts_pin | input | 1 | External clear-to-send line, asynchronous |
| dsr_pin | input | 1 | External data-set-ready line, asynchronous |
| ri_pin | input | 1 | External ring line, asynchronous |
| dcd_pin | input | 1 | External carrier-detect line, asynchronous |
| msr_rd | input | 1 | Read strobe for the status byte; clears bits 3:0 |
| msr_o | output | 8 | Registered modem status byte |

## Verification
The bench drives the ring line in both directions, with and without a read in the same cycle. A design that flags every ring change would show bit 2 after the rising edge. It also checks a read that coincides with a new carrier change. A design that lets the clear win would lose that flag. The bench holds the pins high while in loopback and changes the control bits while in normal mode. A wrong source mux would leak the wrong value into the upper nibble. It also samples the upper nibble one cycle before the synchroniser latency has elapsed. A design with too few or too many synchroniser stages fails there.

// File: rtl/msl_pkg.sv
package msl_pkg;
  // control byte bit positions
  localparam int CTL_DTR  = 0;
  localparam int CTL_RTS  = 1;
  localparam int CTL_OUT1 = 2;
  localparam int CTL_OUT2 = 3;
  localparam int CTL_LOOP = 4;

  localparam int LINES = 4;

  // line nibble, packed so that it maps onto status bits 7:4
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mline_t;

  // lanes whose flag records only a 1-to-0 transition (ring lane)
  localparam logic [LINES-1:0] TRAIL_ONLY = 4'b0100;
endpackage

// File: rtl/msl_sync.sv
module msl_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/msl_src_sel.sv
module msl_src_sel
  import msl_pkg::*;
(
  input  logic       loop_en,
  input  logic [3:0] ctl,
  input  mline_t     ext,
  output mline_t     src
);
  mline_t looped;

  always_comb begin
    looped.cts = ctl[CTL_RTS];
    looped.dsr = ctl[CTL_DTR];
    looped.ri  = ctl[CTL_OUT1];
    looped.dcd = ctl[CTL_OUT2];
    src = loop_en ? looped : ext;
  end
endmodule

// File: rtl/msl_status_reg.sv
module msl_status_reg
  import msl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  mline_t           nxt,
  input  logic             rd,
  output logic [2*LINES-1:0] status
);
  logic [LINES-1:0] line_q;
  logic [LINES-1:0] flag_q;
  logic [LINES-1:0] event_w;
  logic [LINES-1:0] nxt_w;

  assign nxt_w = nxt;

  for (genvar i = 0; i < LINES; i++) begin : g_lane
    if (TRAIL_ONLY[i]) begin : g_trail
      assign event_w[i] = line_q[i] & ~nxt_w[i];
    end else begin : g_any
      assign event_w[i] = line_q[i] ^ nxt_w[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      flag_q <= '0;
    end else begin
      line_q <= nxt_w;
      flag_q <= (rd ? '0 : flag_q) | event_w;
    end
  end

  assign status = {line_q, flag_q};
endmodule

// File: rtl/modem_status_loop.sv
module modem_status_loop
  import msl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] mcr_i,
  input  logic       cts_pin,
  input  logic       dsr_pin,
  input  logic       ri_pin,
  input  logic       dcd_pin,
  input  logic       msr_rd,
  output logic [7:0] msr_o
);
  logic [LINES-1:0] pins_raw;
  logic [LINES-1:0] pins_sync;
  mline_t           ext_line;
  mline_t           src_line;
  logic             unused_ctl_hi;

  assign pins_raw      = {dcd_pin, ri_pin, dsr_pin, cts_pin};
  assign unused_ctl_hi = ^mcr_i[7:5];

  msl_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_sync)
  );

  assign ext_line = pins_sync;

  msl_src_sel u_sel (
    .loop_en (mcr_i[CTL_LOOP]),
    .ctl     (mcr_i[3:0]),
    .ext     (ext_line),
    .src     (src_line)
  );

  msl_status_reg u_stat (
    .clk    (clk),
    .rst    (rst),
    .nxt    (src_line),
    .rd     (msr_rd),
    .status (msr_o)
  );
endmodule

// File: rtl/msl_checker.sv
module msl_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] mcr,
  input logic       rd,
  input logic [7:0] msr
);
  p_loop_cts_r1: assert property (@(posedge clk) disable iff (rst)
    mcr[4] |=> msr[4] == $past(mcr[1]));

  p_loop_dsr_r2: assert property (@(posedge clk) disable iff (rst)
    mcr[4] |=> msr[5] == $past(mcr[0]));

  p_loop_ri_dcd_r3: assert property (@(posedge clk) disable iff (rst)
    mcr[4] |=> (msr[6] == $past(mcr[2])) && (msr[7] == $past(mcr[3])));

  p_delta_any_r4: assert property (@(posedge clk) disable iff (rst)
    ((msr[4] != $past(msr[4])) |-> msr[0]) and
    ((msr[5] != $past(msr[5])) |-> msr[1]) and
    ((msr[7] != $past(msr[7])) |-> msr[3]));

  p_teri_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(msr[6]) |-> msr[2]);

  p_teri_rise_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(msr[6]) && $past(rd)) |-> !msr[2]);

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rd) |-> ((msr[3:0] & $past(msr[3:0])) == $past(msr[3:0])));

  p_rd_clear_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(rd) && (msr[7:4] == $past(msr[7:4]))) |-> msr[3:0] == 4'h0);
endmodule

bind modem_status_loop msl_checker u_chk (
  .clk (clk),
  .rst (rst),
  .mcr (mcr_i),
  .rd  (msr_rd),
  .msr (msr_o)
);

// File: tb/modem_status_loop_test.sv
module modem_status_loop_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mcr = 8'h00;
  logic [3:0] pins = 4'h0;  // {dcd, ri, dsr, cts}
  logic       rd = 1'b0;
  logic [7:0] msr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  modem_status_loop #(.SYNC_STAGES(2)) uut (
    .clk     (clk),
    .rst     (rst),
    .mcr_i   (mcr),
    .cts_pin (pins[0]),
    .dsr_pin (pins[1]),
    .ri_pin  (pins[2]),
    .dcd_pin (pins[3]),
    .msr_rd  (rd),
    .msr_o   (msr)
  );

  // monitor: pops expectations and compares away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (msr !== e) begin
        errors++;
        $display("FAIL %s: msr actual=%02h expected=%02h", t, msr, e);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=5000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // driver: applies inputs, waits lat edges (read only in the first), queues expectation
  task automatic cyc(input logic [7:0] m, input logic [3:0] p, input logic r,
                     input int lat, input logic [7:0] e, input string t);
    @(negedge clk);
    mcr  = m;
    pins = p;
    rd   = r;
    for (int k = 0; k < lat; k++) begin
      @(posedge clk);
      #1 rd = 1'b0;
    end
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc(8'h00, 4'h0, 0, 1, 8'h00, "R9 reset state");
    cyc(8'h12, 4'h0, 0, 1, 8'h11, "R1/R4 cts follows rts, flag set");
    cyc(8'h12, 4'h0, 1, 1, 8'h10, "R8 read clears flags");
    cyc(8'h13, 4'h0, 0, 1, 8'h32, "R2 dsr follows dtr");
    cyc(8'h13, 4'hF, 0, 1, 8'h32, "R7 pins ignored in loopback, R6 sticky");
    cyc(8'h17, 4'hF, 1, 1, 8'h70, "R5 ring rise sets no flag, R3");
    cyc(8'h13, 4'hF, 0, 1, 8'h34, "R5 ring fall sets flag");
    cyc(8'h1B, 4'hF, 1, 1, 8'hB8, "R8 event in read cycle survives, R3 dcd");
    cyc(8'hFB, 4'hF, 0, 1, 8'hB8, "R7 control bits 7:5 ignored, R6 sticky");
    cyc(8'h19, 4'hF, 1, 1, 8'hA1, "R1/R4 cts falls, flag set");
    cyc(8'h00, 4'hF, 1, 1, 8'hF1, "R7 normal mode takes pins, ignores control");
    cyc(8'h00, 4'hB, 1, 2, 8'hF0, "R7 pin not visible before latency");
    cyc(8'h00, 4'hB, 0, 1, 8'hB4, "R7/R5 external ring fall after latency");
    cyc(8'h00, 4'h9, 0, 3, 8'h96, "R4 external dsr fall");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    exp_q.push_back(8'h00);
    tag_q.push_back("R9 reset clears status");
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(posedge clk);
    exp_q.push_back(8'h99);
    tag_q.push_back("R9/R4 sync restarts from zero after reset");
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule